// File: doc/BRIEF.md
# Serially Configured Internal Probe Router

This block lets a debugger watch internal nodes of a running design without touching it. A small array of observable cells is arranged in eight rows of four columns. Each row forms a tile. A serial control port lets an external debugger shift a selection word into a holding register and then commit it with an update strobe. The committed selection routes one chosen cell to each of four probe outputs.

Each probe output follows its cell's live value through combinational logic only, so the observed logic never sees an extra load, register or timing change. No more than two enabled probes may point into the same tile. An update that breaks this rule is refused as a whole. A lock input stands in for a security fuse: while it is high, every probe output is held low and every update is refused. A sticky flag on the serial output reports whether the most recent update was refused.

Top module: `probe_router`

## Requirements
- R1: After reset the committed selection has every channel disabled, all four probe outputs are 0 and the refusal flag on `tdo_o` is 0.
- R2: On each clock with `shift_i` high, `tdi_i` enters the holding register at its most significant end, so after 24 strobes the first bit sent sits at bit 0. Channel c uses bits [6c+5:6c]: bit 6c is the enable, bits [6c+2:6c+1] are the column and bits [6c+5:6c+3] are the row (tile).
- R3: An `update_i` strobe that is accepted copies all 24 bits into the committed selection at the next clock edge. Shifting alone never changes the probe outputs.
- R4: An enabled channel drives `cells_i[row*4+col]` combinationally: a change of `cells_i` shows on the probe in the same cycle.
- R5: A disabled channel drives 0 whatever the cell values are.
- R6: The four channels are independent. Any two of them may select the same cell or different cells at the same time.
- R7: If more than two enabled channels name the same row, the update is refused as a whole and every channel keeps its previous selection.
- R8: While `lock_i` is high, all probe outputs are 0 and updates are refused. When the lock is released, the previously committed selection shows again.
- R9: `tdo_o` goes to 1 after a refused update (a tile-limit breach or the lock) and returns to 0 after an accepted update. No other event changes it.
- R10: Disabled channels do not count toward the per-tile limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Fuse-style probe lockout |
| shift_i | input | 1 | Shift strobe for the holding register |
| tdi_i | input | 1 | Serial data in |
| update_i | input | 1 | Commit strobe |
| cells_i | input | 32 | Live values of the observable cells |
| probe_o | output | 4 | Probe channel outputs |
| tdo_o | output | 1 | Refusal flag of the last update |

## Verification
For every one of the 32 cells, the bench loads a selection in which two channels share a tile and the other two sit in different tiles. It then drives a walking one and all-zero and all-one patterns over the cells. This shows whether each channel decodes its row and column correctly and whether the channels route independently. A sweep over every enable combination with every two-tile row assignment tells legal updates apart from refused ones, and shows that disabled channels do not count toward the tile limit. The probes are checked after every shift strobe, which separates a commit made by the update strobe from leakage while shifting. Lock cycles with updates attempted during them show the forced-low outputs, the refusal flag, and that the old selection returns afterwards.

// File: rtl/probe_pkg.sv
// Shared geometry of the probe router: channel count, coordinate widths
// and the per-tile limit. Everything else derives from these values.
package probe_pkg;
    localparam int NUM_CH    = 4;
    localparam int ROW_W     = 3;
    localparam int COL_W     = 2;
    localparam int TILE_MAX  = 2;
    localparam int FIELD_W   = 1 + COL_W + ROW_W;
    localparam int SEL_W     = NUM_CH * FIELD_W;
    localparam int NUM_CELLS = 2 ** (ROW_W + COL_W);
endpackage

// File: rtl/probe_shift.sv
// Serial holding register. Bits enter at the top and move toward bit 0 on
// each shift strobe, so a word sent least significant bit first lands in
// place. Assumes the strobe is synchronous to clk.
module probe_shift #(
    parameter int W = probe_pkg::SEL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         tdi_i,
    output logic [W-1:0] sr_o
);
    logic [W-1:0] sr_q;

    // Shift one serial bit in per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= {tdi_i, sr_q[W-1:1]};
    end

    assign sr_o = sr_q;

    a_r2_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(sr_q));
    a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> sr_q[W-1] == $past(tdi_i));
endmodule

// File: rtl/probe_tile_check.sv
// Checks a candidate selection against the per-tile limit. Purely
// combinational; only enabled channels are counted.
module probe_tile_check
    import probe_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int RW   = ROW_W,
    parameter int CW   = COL_W,
    parameter int LIM  = TILE_MAX,
    localparam int FW  = 1 + CW + RW,
    localparam int SW  = NCH * FW
) (
    input  logic [SW-1:0] sel_i,
    output logic          ok_o
);
    // Count the enabled channels per row and flag any row above the limit.
    always_comb begin
        ok_o = 1'b1;
        for (int r = 0; r < 2 ** RW; r++) begin
            int cnt;
            cnt = 0;
            for (int c = 0; c < NCH; c++) begin
                if (sel_i[c*FW] && (sel_i[c*FW+1+CW +: RW] == RW'(r)))
                    cnt++;
            end
            if (cnt > LIM) ok_o = 1'b0;
        end
    end
endmodule

// File: rtl/probe_mux.sv
// One probe channel: picks a cell by row and column and gates it with the
// channel enable and the lock. No registers lie in the path, so the probe
// follows the cell in the same cycle.
module probe_mux
    import probe_pkg::*;
#(
    parameter int RW  = ROW_W,
    parameter int CW  = COL_W,
    localparam int FW = 1 + CW + RW,
    localparam int NC = 2 ** (RW + CW)
) (
    input  logic [NC-1:0] cells_i,
    input  logic [FW-1:0] field_i,
    input  logic          lock_i,
    output logic          probe_o
);
    logic [RW+CW-1:0] idx;

    // Cell index is the row followed by the column.
    assign idx     = {field_i[1+CW +: RW], field_i[1 +: CW]};
    assign probe_o = !lock_i && field_i[0] && cells_i[idx];
endmodule

// File: rtl/probe_router.sv
// Top of the probe router. Holds the committed selection and the refusal
// flag, and instantiates the serial register, the tile-limit check and one
// output mux per channel. Assumes the strobes are synchronous to clk; an
// update in the same cycle as a shift commits the word shifted so far.
module probe_router
    import probe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_i,
    input  logic                 shift_i,
    input  logic                 tdi_i,
    input  logic                 update_i,
    input  logic [NUM_CELLS-1:0] cells_i,
    output logic [NUM_CH-1:0]    probe_o,
    output logic                 tdo_o
);
    logic [SEL_W-1:0] sr;
    logic [SEL_W-1:0] sel_q;
    logic             tile_ok;
    logic             accept;
    logic             status_q;

    probe_shift #(.W(SEL_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_i),
        .tdi_i   (tdi_i),
        .sr_o    (sr)
    );

    probe_tile_check #(.NCH(NUM_CH), .RW(ROW_W), .CW(COL_W), .LIM(TILE_MAX)) u_check (
        .sel_i (sr),
        .ok_o  (tile_ok)
    );

    assign accept = update_i && !lock_i && tile_ok;

    // Commit the holding register when an update is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (accept) sel_q <= sr;
    end

    // Track whether the latest update was refused.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= 1'b0;
        else if (update_i) status_q <= !accept;
    end

    assign tdo_o = status_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        probe_mux #(.RW(ROW_W), .CW(COL_W)) u_mux (
            .cells_i (cells_i),
            .field_i (sel_q[c*FIELD_W +: FIELD_W]),
            .lock_i  (lock_i),
            .probe_o (probe_o[c])
        );

        a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_q[c*FIELD_W] |-> !probe_o[c]);
    end

    a_r3_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && !lock_i && tile_ok) |=> sel_q == $past(sr));
    a_r3_no_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(sel_q));
    a_r7_refuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && !tile_ok) |=> $stable(sel_q));
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && lock_i) |=> $stable(sel_q));
    a_r8_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |-> probe_o == '0);
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && (lock_i || !tile_ok)) |=> tdo_o);
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && !lock_i && tile_ok) |=> !tdo_o);
    a_r9_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(tdo_o));
endmodule

// File: tb/sim_probe_router.sv
module sim_probe_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        shift_i = 1'b0;
    logic        tdi_i = 1'b0;
    logic        update_i = 1'b0;
    logic [31:0] cells_i = '0;
    logic [3:0]  probe_o;
    logic        tdo_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [23:0] m_sel = '0;
    bit          m_flag = 0;

    probe_router u0 (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .shift_i(shift_i),
        .tdi_i(tdi_i), .update_i(update_i), .cells_i(cells_i),
        .probe_o(probe_o), .tdo_o(tdo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] fld(bit en, int row, int col);
        logic [2:0] r;
        logic [1:0] c;
        r = row[2:0];
        c = col[1:0];
        return {r, c, en};
    endfunction

    function automatic bit legal(logic [23:0] v);
        for (int r = 0; r < 8; r++) begin
            int n;
            n = 0;
            for (int c = 0; c < 4; c++)
                if (v[c*6] && v[c*6+3 +: 3] == r[2:0]) n++;
            if (n > 2) return 0;
        end
        return 1;
    endfunction

    function automatic logic [3:0] expect_probes();
        logic [3:0] e;
        for (int c = 0; c < 4; c++) begin
            int idx;
            idx = int'(m_sel[c*6+3 +: 3]) * 4 + int'(m_sel[c*6+1 +: 2]);
            e[c] = !lock_i && m_sel[c*6] && cells_i[idx];
        end
        return e;
    endfunction

    task automatic chk_probes(string tag);
        logic [3:0] e;
        e = expect_probes();
        checks++;
        if (probe_o !== e) begin
            errors++;
            $display("FAIL %s probes actual=%b expected=%b", tag, probe_o, e);
        end
    endtask

    task automatic chk_flag(string tag);
        checks++;
        if (tdo_o !== m_flag) begin
            errors++;
            $display("FAIL %s tdo actual=%b expected=%b", tag, tdo_o, m_flag);
        end
    endtask

    // Shift a word in LSB first; probes must not move while shifting (R3).
    task automatic load(logic [23:0] v);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            shift_i = 1'b1;
            tdi_i   = v[i];
            @(negedge clk);
            shift_i = 1'b0;
            chk_probes("R3 shift");
        end
    endtask

    task automatic commit(logic [23:0] v);
        @(negedge clk);
        update_i = 1'b1;
        @(negedge clk);
        update_i = 1'b0;
        if (!lock_i && legal(v)) begin
            m_sel  = v;
            m_flag = 0;
        end else begin
            m_flag = 1;
        end
    endtask

    task automatic load_commit(logic [23:0] v, string tag);
        load(v);
        commit(v);
        chk_probes(tag);
        chk_flag(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cells_i = '1;
        #1;
        chk_probes("R1 reset");
        chk_flag("R1 reset");
        checks++;
        if (probe_o !== 4'b0000) begin
            errors++;
            $display("FAIL R1 probes actual=%b expected=0000", probe_o);
        end

        // R2 R4 R6: every cell, two channels sharing a tile, walking patterns.
        for (int k = 0; k < 32; k++) begin
            logic [23:0] v;
            int k2, k3;
            k2 = (k + 4) % 32;
            k3 = (k + 9) % 32;
            v = {fld(1, k3 / 4, k3 % 4), fld(1, k2 / 4, k2 % 4),
                 fld(1, k / 4, (k % 4) ^ 1), fld(1, k / 4, k % 4)};
            load_commit(v, "R2 R6 commit");
            for (int b = 0; b < 34; b++) begin
                cells_i = (b < 32) ? (32'h1 << b) : ((b == 32) ? 32'h0 : 32'hFFFF_FFFF);
                #1;
                chk_probes("R4 R6 walk");
            end
            @(negedge clk);
            cells_i = ~cells_i;
            @(negedge clk);
            cells_i = 32'h1 << k;
            #1;
            chk_probes("R4 same cycle");
        end

        // R5: every enable mask, distinct rows.
        cells_i = '1;
        for (int m = 0; m < 16; m++) begin
            logic [23:0] v;
            v = {fld(m[3], 6, 3), fld(m[2], 4, 2), fld(m[1], 2, 1), fld(m[0], 0, 0)};
            load_commit(v, "R5 enable mask");
        end

        // R7 R10 R9: every enable mask with every row assignment drawn from {1,5}.
        cells_i = 32'hA5C3_0F96;
        for (int rs = 0; rs < 16; rs++) begin
            for (int m = 0; m < 16; m++) begin
                logic [23:0] v;
                v = {fld(m[3], rs[3] ? 5 : 1, 3), fld(m[2], rs[2] ? 5 : 1, 2),
                     fld(m[1], rs[1] ? 5 : 1, 1), fld(m[0], rs[0] ? 5 : 1, 0)};
                load_commit(v, "R7 R10 tile limit");
            end
        end

        // R8: lock forces zero, refuses updates, and old selection returns.
        load_commit({fld(1, 7, 0), fld(1, 3, 3), fld(1, 2, 1), fld(1, 0, 2)}, "R8 setup");
        cells_i = '1;
        @(negedge clk);
        lock_i = 1'b1;
        #1;
        chk_probes("R8 locked low");
        load_commit({fld(1, 1, 0), fld(1, 1, 1), fld(0, 4, 1), fld(1, 5, 2)}, "R8 R9 locked update");
        cells_i = 32'h0F0F_F0F0;
        #1;
        chk_probes("R8 locked low");
        @(negedge clk);
        lock_i = 1'b0;
        cells_i = '1;
        #1;
        chk_probes("R8 released");
        checks++;
        if (probe_o !== 4'b1111) begin
            errors++;
            $display("FAIL R8 released actual=%b expected=1111", probe_o);
        end
        load_commit({fld(1, 1, 0), fld(1, 1, 1), fld(1, 4, 1), fld(1, 5, 2)}, "R9 clear");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule